// File: doc/BRIEF.md
# Condition Code Flag Unit

This block holds an 8-bit condition code register and computes its next value after each arithmetic, shift or test operation performed elsewhere in the datapath. The ALU supplies the operation class, a width select (8- or 16-bit), both operands and the result it produced. The unit derives carry, overflow, sign, zero and half-carry from the sign bits of those three values. It writes back only the flags that the operation class defines. All other flags keep their value.

A per-flag direct write path sits alongside the arithmetic path. It lets the sequencer force any subset of flags to a chosen value, for example for flag set/clear instructions or a register transfer into the CCR. When a direct write and an operation arrive in the same cycle, the direct write wins on the bits it selects. The registered CCR is the only output.

Bit layout of the CCR (bit 7 down to bit 0): S, X, H, I, N, Z, V, C. Operation codes on `op_kind`: 0 = none, 1 = add, 2 = subtract, 3 = shift, 4 = test. Codes 5 to 7 behave as none.

Top module: `ccr_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the CCR loads 0xD0 (S, X and I set, all other bits clear).
- R2: For add, C becomes the sign bit of (a&b)|(b&~r)|(a&~r), and V becomes the sign bit of (a&b&~r)|(~a&~b&r). The sign bit is bit 7 when `wide`=0 and bit 15 when `wide`=1.
- R3: For subtract, C becomes the sign bit of (~a&b)|(b&r)|(~a&r), and V becomes the sign bit of (a&~b&~r)|(~a&b&r). The sign bit is chosen by width as in R2.
- R4: For add, subtract, shift and test, N takes the sign bit of r, and Z is set exactly when r is zero. When `wide`=0, only r[7:0] is considered and r[15:8] has no effect.
- R5: For test, V is cleared, N and Z follow R4, and C keeps its previous value.
- R6: For shift, C takes `shift_c`, N and Z follow R4, and V becomes the new N XOR the new C.
- R7: Only an 8-bit add writes H, and it writes the carry out of bit 3: bit 3 of (a&b)|(b&~r)|(a&~r). All other operations, including a 16-bit add, leave H unchanged.
- R8: When `dir_en[k]` is 1, bit k of the CCR takes `dir_val[k]` on the next edge. This overrides any operation in the same cycle. Bits with `dir_en[k]`=0 are not disturbed by the direct path.
- R9: Operations never change S, X or I. With op code none (or 5 to 7) and `dir_en`=0, the whole CCR holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_kind | input | 3 | Operation class: 0 none, 1 add, 2 subtract, 3 shift, 4 test |
| wide | input | 1 | 1 selects 16-bit flag rules, 0 selects 8-bit |
| opnd_a | input | 16 | First ALU operand |
| opnd_b | input | 16 | Second ALU operand |
| alu_res | input | 16 | Result produced by the ALU |
| shift_c | input | 1 | Carry bit produced by the shifter |
| dir_en | input | 8 | Per-flag direct write select |
| dir_val | input | 8 | Per-flag direct write value |
| ccr_q | output | 8 | Registered condition code register |

## Verification
The assertions assume that every input is a known value at each rising edge outside reset. They also assume that `alu_res` relates to the operands as the operation class says. The overflow-after-shift check relies on the shift carry being presented in the same cycle as the shifted result. The bench therefore drives all inputs at the falling edge, holds them across the rising edge, and builds each `alu_res` as the true sum, difference or shifted value of its operands. It also drives all inputs to zero during reset.

// File: rtl/ccr_pkg.sv
// Package: shared widths, CCR bit positions and operation codes.
// Assumes an 8-bit CCR; the bit positions are fixed because the
// sequencer and branch logic decode them.
package ccr_pkg;
    localparam int CCR_W   = 8;
    localparam int DATA_W  = 16;
    localparam int HALF_W  = DATA_W / 2;
    localparam int NIB_BIT = HALF_W / 2 - 1;

    localparam int B_S = 7;
    localparam int B_X = 6;
    localparam int B_H = 5;
    localparam int B_I = 4;
    localparam int B_N = 3;
    localparam int B_Z = 2;
    localparam int B_V = 1;
    localparam int B_C = 0;

    localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

    typedef enum logic [2:0] {
        OPK_NONE  = 3'd0,
        OPK_ADD   = 3'd1,
        OPK_SUB   = 3'd2,
        OPK_SHIFT = 3'd3,
        OPK_TEST  = 3'd4
    } opk_e;
endpackage

// File: rtl/ccr_flag_calc.sv
// Flag calculator: combinational next-CCR from an ALU operation.
// Assumes alu_res is the result the ALU produced from opnd_a/opnd_b;
// bits not defined by the operation class pass through from cur.
module ccr_flag_calc
    import ccr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int HW = HALF_W,
    parameter int NB = NIB_BIT
) (
    input  logic [2:0]       op_kind,
    input  logic             wide,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    input  logic [DW-1:0]    alu_res,
    input  logic             shift_c,
    input  logic [CCR_W-1:0] cur,
    output logic [CCR_W-1:0] nxt
);
    logic [DW-1:0] add_cv, add_ov, sub_cv, sub_ov;
    logic          sgn_r, zero_r;
    logic          add_c, add_v, sub_c, sub_v;

    // Carry and overflow bit-vectors for every bit position.
    always_comb begin
        add_cv = (opnd_a & opnd_b) | (opnd_b & ~alu_res) | (opnd_a & ~alu_res);
        add_ov = (opnd_a & opnd_b & ~alu_res) | (~opnd_a & ~opnd_b & alu_res);
        sub_cv = (~opnd_a & opnd_b) | (opnd_b & alu_res) | (~opnd_a & alu_res);
        sub_ov = (opnd_a & ~opnd_b & ~alu_res) | (~opnd_a & opnd_b & alu_res);
    end

    // Pick the sign position and zero test for the selected width.
    always_comb begin
        if (wide) begin
            sgn_r  = alu_res[DW-1];
            zero_r = (alu_res == '0);
            add_c  = add_cv[DW-1];
            add_v  = add_ov[DW-1];
            sub_c  = sub_cv[DW-1];
            sub_v  = sub_ov[DW-1];
        end else begin
            sgn_r  = alu_res[HW-1];
            zero_r = (alu_res[HW-1:0] == '0);
            add_c  = add_cv[HW-1];
            add_v  = add_ov[HW-1];
            sub_c  = sub_cv[HW-1];
            sub_v  = sub_ov[HW-1];
        end
    end

    // Merge the flags each operation class defines over the current CCR.
    always_comb begin
        nxt = cur;
        case (op_kind)
            OPK_ADD: begin
                nxt[B_C] = add_c;
                nxt[B_V] = add_v;
                nxt[B_N] = sgn_r;
                nxt[B_Z] = zero_r;
                if (!wide) nxt[B_H] = add_cv[NB];
            end
            OPK_SUB: begin
                nxt[B_C] = sub_c;
                nxt[B_V] = sub_v;
                nxt[B_N] = sgn_r;
                nxt[B_Z] = zero_r;
            end
            OPK_SHIFT: begin
                nxt[B_C] = shift_c;
                nxt[B_N] = sgn_r;
                nxt[B_Z] = zero_r;
                nxt[B_V] = sgn_r ^ shift_c;
            end
            OPK_TEST: begin
                nxt[B_V] = 1'b0;
                nxt[B_N] = sgn_r;
                nxt[B_Z] = zero_r;
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ccr_direct_merge.sv
// Direct write merge: per-bit override of the operation result.
// Assumes dir_en and dir_val are aligned with the CCR bit layout.
module ccr_direct_merge
    import ccr_pkg::*;
#(
    parameter int W = CCR_W
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] dir_en,
    input  logic [W-1:0] dir_val,
    output logic [W-1:0] merged
);
    for (genvar k = 0; k < W; k++) begin : g_bit
        // Selected bit takes the requested value, others pass through.
        assign merged[k] = dir_en[k] ? dir_val[k] : base[k];
    end
endmodule

// File: rtl/ccr_unit.sv
// Condition code unit top: flag calculation, direct override, register.
// Assumes inputs are stable around each rising edge; reset is
// synchronous and active low.
module ccr_unit
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_kind,
    input  logic              wide,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              shift_c,
    input  logic [CCR_W-1:0]  dir_en,
    input  logic [CCR_W-1:0]  dir_val,
    output logic [CCR_W-1:0]  ccr_q
);
    logic [CCR_W-1:0] alu_next;
    logic [CCR_W-1:0] final_next;

    ccr_flag_calc #(.DW(DATA_W), .HW(HALF_W), .NB(NIB_BIT)) u_calc (
        .op_kind (op_kind),
        .wide    (wide),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .alu_res (alu_res),
        .shift_c (shift_c),
        .cur     (ccr_q),
        .nxt     (alu_next)
    );

    ccr_direct_merge #(.W(CCR_W)) u_merge (
        .base    (alu_next),
        .dir_en  (dir_en),
        .dir_val (dir_val),
        .merged  (final_next)
    );

    // CCR register with synchronous reset to the power-up mask.
    always_ff @(posedge clk) begin
        if (!rst_n) ccr_q <= CCR_RESET;
        else        ccr_q <= final_next;
    end

    // Idle cycle holds the whole register.
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(op_kind inside {OPK_ADD, OPK_SUB, OPK_SHIFT, OPK_TEST}) && dir_en == '0)
        |=> $stable(ccr_q));

    // Operations never reach S, X or I.
    assert_sxi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_en[B_S] && !dir_en[B_X] && !dir_en[B_I])
        |=> (ccr_q[B_S] == $past(ccr_q[B_S]) && ccr_q[B_X] == $past(ccr_q[B_X])
             && ccr_q[B_I] == $past(ccr_q[B_I])));

    // Test clears V and leaves C alone.
    assert_test_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OPK_TEST && !dir_en[B_V] && !dir_en[B_C])
        |=> (!ccr_q[B_V] && ccr_q[B_C] == $past(ccr_q[B_C])));

    // After a shift, V equals N XOR C as stored.
    assert_shift_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OPK_SHIFT && !dir_en[B_V] && !dir_en[B_N] && !dir_en[B_C])
        |=> (ccr_q[B_V] == (ccr_q[B_N] ^ ccr_q[B_C])));

    // H moves only on an 8-bit add or a direct write.
    assert_h_only_add8_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(op_kind == OPK_ADD && !wide) && !dir_en[B_H])
        |=> $stable(ccr_q[B_H]));

    // Directly written bits carry the requested value.
    assert_direct_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_en != '0)
        |=> (((ccr_q ^ $past(dir_val)) & $past(dir_en)) == '0));
endmodule

// File: tb/ccr_unit_bench.sv
module ccr_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_kind = '0;
    logic        wide = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0, alu_res = '0;
    logic        shift_c = 1'b0;
    logic [7:0]  dir_en = '0, dir_val = '0;
    logic [7:0]  ccr_q;

    int total = 0;
    int bad = 0;
    logic [7:0] model = 8'h00;

    ccr_unit u_ccr_unit (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .wide(wide),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .alu_res(alu_res),
        .shift_c(shift_c), .dir_en(dir_en), .dir_val(dir_val), .ccr_q(ccr_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected CCR from the requirement text (bit 7..0 = S X H I N Z V C).
    function automatic logic [7:0] expect_next(input logic [7:0] cur,
        input logic [2:0] k, input logic w, input logic [15:0] a,
        input logic [15:0] b, input logic [15:0] r, input logic sc,
        input logic [7:0] en, input logic [7:0] val);
        logic [7:0] e;
        int sb;
        logic n, z;
        logic [15:0] ca;
        e  = cur;
        sb = w ? 15 : 7;
        n  = r[sb];
        z  = w ? (r == 16'h0) : (r[7:0] == 8'h0);
        ca = (a & b) | (b & ~r) | (a & ~r);
        if (k == 3'd1) begin
            e[0] = ca[sb];
            e[1] = ((a & b & ~r) | (~a & ~b & r)) >> sb;
            e[3] = n; e[2] = z;
            if (!w) e[5] = ca[3];
        end else if (k == 3'd2) begin
            e[0] = ((~a & b) | (b & r) | (~a & r)) >> sb;
            e[1] = ((a & ~b & ~r) | (~a & b & r)) >> sb;
            e[3] = n; e[2] = z;
        end else if (k == 3'd3) begin
            e[0] = sc; e[3] = n; e[2] = z; e[1] = n ^ sc;
        end else if (k == 3'd4) begin
            e[1] = 1'b0; e[3] = n; e[2] = z;
        end
        return (e & ~en) | (val & en);
    endfunction

    task automatic check(input string req, input logic [7:0] exp_v);
        total++;
        if (ccr_q !== exp_v) begin
            bad++;
            $display("FAIL %s: ccr actual=%02h expected=%02h", req, ccr_q, exp_v);
        end
    endtask

    // Drive one cycle at the falling edge, sample after the rising edge.
    task automatic step(input logic [2:0] k, input logic w, input logic [15:0] a,
        input logic [15:0] b, input logic [15:0] r, input logic sc,
        input logic [7:0] en, input logic [7:0] val);
        @(negedge clk);
        op_kind = k; wide = w; opnd_a = a; opnd_b = b; alu_res = r;
        shift_c = sc; dir_en = en; dir_val = val;
        model = expect_next(model, k, w, a, b, r, sc, en, val);
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        model = 8'hD0;
        check("R1 reset value", 8'hD0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_add8();
        step(3'd1, 1'b0, 16'h007F, 16'h0001, 16'h0080, 1'b0, 8'h00, 8'h00);
        check("R2 add8 signed overflow", model);
        check("R7 add8 half carry set", {2'b11, 1'b1, 1'b1, 4'b1010});
        step(3'd1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 8'h00, 8'h00);
        check("R2 add8 carry and zero", model);
        step(3'd1, 1'b0, 16'h0012, 16'h0021, 16'h0033, 1'b0, 8'h00, 8'h00);
        check("R7 add8 no half carry", model);
    endtask

    task automatic t_add16();
        step(3'd1, 1'b0, 16'h0008, 16'h0008, 16'h0010, 1'b0, 8'h00, 8'h00);
        step(3'd1, 1'b1, 16'h8000, 16'h8000, 16'h0000, 1'b0, 8'h00, 8'h00);
        check("R2 add16 carry overflow zero, R7 H kept", model);
        step(3'd1, 1'b1, 16'h4000, 16'h4000, 16'h8000, 1'b0, 8'h00, 8'h00);
        check("R2 add16 overflow", model);
    endtask

    task automatic t_sub();
        step(3'd2, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, 8'h00, 8'h00);
        check("R3 sub8 borrow", model);
        step(3'd2, 1'b0, 16'h0080, 16'h0001, 16'h007F, 1'b0, 8'h00, 8'h00);
        check("R3 sub8 overflow", model);
        step(3'd2, 1'b1, 16'h1234, 16'h1234, 16'h0000, 1'b0, 8'h00, 8'h00);
        check("R3 sub16 equal gives zero", model);
        step(3'd2, 1'b1, 16'h0100, 16'h0200, 16'hFF00, 1'b0, 8'h00, 8'h00);
        check("R3 sub16 borrow", model);
    endtask

    task automatic t_width();
        step(3'd4, 1'b0, 16'h0, 16'h0, 16'hAB00, 1'b0, 8'h00, 8'h00);
        check("R4 upper byte ignored in 8-bit zero", model);
        step(3'd4, 1'b1, 16'h0, 16'h0, 16'hAB00, 1'b0, 8'h00, 8'h00);
        check("R4 16-bit sign and nonzero", model);
    endtask

    task automatic t_test();
        step(3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'h03, 8'h03);
        step(3'd4, 1'b0, 16'h0, 16'h0, 16'h0045, 1'b0, 8'h00, 8'h00);
        check("R5 test clears V keeps C", model);
    endtask

    task automatic t_shift();
        step(3'd3, 1'b0, 16'h0, 16'h0, 16'h0080, 1'b0, 8'h00, 8'h00);
        check("R6 shift N set C clear", model);
        step(3'd3, 1'b0, 16'h0, 16'h0, 16'h0080, 1'b1, 8'h00, 8'h00);
        check("R6 shift N and C set", model);
        step(3'd3, 1'b1, 16'h0, 16'h0, 16'h0000, 1'b1, 8'h00, 8'h00);
        check("R6 shift16 zero with carry", model);
    endtask

    task automatic t_direct();
        step(3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'h90, 8'h00);
        check("R8 clear S and I only", model);
        step(3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'h20, 8'hFF);
        check("R8 set H only", model);
        step(3'd1, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 1'b0, 8'h01, 8'h00);
        check("R8 direct beats add on C", model);
    endtask

    task automatic t_hold();
        step(3'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 8'hFF, 8'hD5);
        step(3'd6, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 8'h00, 8'h00);
        check("R9 unused code holds", 8'hD5);
        idle();
        check("R9 idle holds", 8'hD5);
        step(3'd2, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0, 8'h00, 8'h00);
        check("R9 S X I untouched by op", {model[7:6], 1'b0, model[4], 4'b1001} & 8'hD0 | (model & 8'h2F));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_add8();
        t_add16();
        t_sub();
        t_width();
        t_test();
        t_shift();
        t_direct();
        t_hold();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule